// File: doc/BRIEF.md
# Power-Constrained Variable-Period Scan Clock Generator

This block drives the shift and capture clock of a whole scan test, choosing a new period for every test cycle. Before a test, software fills a small table with one precomputed energy figure per cycle. While a cycle is being clocked out, the block fetches the energy for the following cycle and divides it by a programmable peak-power limit in a sequential divider. A cycle that dissipates little energy therefore gets a short period, and an energetic one gets a long period. The arithmetic never lengthens a cycle. Periods are counted in ticks of the fast reference clock `clk_i`.

Each period is bounded from below by a programmable floor: one for shift cycles and one for capture cycles. A fixed hardware floor covers the divider latency, and another floor keeps the high phase of the clock inside the period. A synchronous mode replaces the per-cycle table value with a single worst-case energy, which gives one fixed period for comparison. The block also walks the shift/capture order of the test, drives scan enable and the index of the current cycle, and keeps a running total of the reference ticks that the test has used.

Top module: `vscan_clk_gen`

## Requirements
- R1: While reset is held, and in idle, `scan_clk_o`, `scan_en_o`, `busy_o` and `done_o` are 0. After reset `tick_cnt_o` is 0.
- R2: With `n_sff_i` = n (n >= 1) and `n_comb_i` = v, one run produces exactly (v+2)·n + v + 4 scan clock periods. `cycle_idx_o` is 0 in the first period and rises by 1 at each following rising edge of `scan_clk_o`.
- R3: `scan_en_o` is 1 in shift cycles and 0 in capture cycles. The capture cycles are those with index 2n+4+j·(n+1), for j = 0 … v−1. Every other cycle is a shift cycle.
- R4: In variable mode (`sync_mode_i` = 0) the period of cycle i, in ticks, is the largest of these four values: ceil(4·E/`p_max_i`), the minimum for the cycle type, 13, and H+1. E is the table entry at address i mod 16. H is defined in R7. The factor 4 and the floor 13 apply at the default parameters, and 13 is the divider latency plus 2. Results above 4095 saturate to 4095.
- R5: The minimum for the cycle type is `min_shift_i` in shift cycles and `min_cap_i` in capture cycles.
- R6: In synchronous mode (`sync_mode_i` = 1) every cycle uses E = `e_max_i` in the R4 formula, regardless of the table contents.
- R7: Each period starts with exactly H ticks of `scan_clk_o` high, where H = max(`high_i`, 2). The clock is low for the rest of the period.
- R8: `busy_o` goes to 1 on the clock edge that accepts `start_i` and stays at 1 until the last period ends. At that same edge `done_o` goes to 1. `done_o` then holds at 1 until the next accepted start.
- R9: At the end of a run, `tick_cnt_o` equals the sum of all periods of that run. It is cleared when a start is accepted.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect on the sequence, the periods or the tick total of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan test (accepted when idle) |
| sync_mode_i | input | 1 | 1: fixed worst-case energy for every cycle |
| p_max_i | input | 8 | Peak-power limit (divisor) |
| e_max_i | input | 8 | Worst-case energy used in synchronous mode |
| min_shift_i | input | 12 | Minimum period of shift cycles, ticks |
| min_cap_i | input | 12 | Minimum period of capture cycles, ticks |
| high_i | input | 12 | Requested high time, ticks (at least 2 is used) |
| n_sff_i | input | 8 | Length of the longest scan chain |
| n_comb_i | input | 8 | Number of capture vectors |
| mem_we_i | input | 1 | Energy table write strobe |
| mem_addr_i | input | 4 | Energy table write address |
| mem_data_i | input | 8 | Energy table write data |
| scan_clk_o | output | 1 | Variable-period scan clock |
| scan_en_o | output | 1 | Scan enable, 0 in capture cycles |
| cycle_idx_o | output | 18 | Index of the current test cycle |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Last test finished |
| tick_cnt_o | output | 32 | Ticks spent in the current or last test |

## Verification
A corrupted segment or vector counter in the sequencer shows up as soon as its error reaches a cycle boundary. The symptoms at the ports are `scan_en_o` dropping at the wrong index, a missing capture, or a run with the wrong number of periods. A wrong dividend, divisor or selected minimum changes the measured distance between two rising edges of `scan_clk_o`, and the error appears in the very next period. A fault in the phase counter or in the high-time compare changes the high time, or the tick total at the end of the run, within one period.

// File: rtl/vscan_pkg.sv
`timescale 1ns/1ps
package vscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } vscan_st_e;
endpackage

// File: rtl/vscan_energy_mem.sv
`timescale 1ns/1ps
module vscan_energy_mem #(
  parameter int EW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/vscan_period_div.sv
`timescale 1ns/1ps
module vscan_period_div #(
  parameter int EW      = 8,
  parameter int PW      = 8,
  parameter int K_SCALE = 4,
  parameter int NUMW    = 11,
  parameter int TW      = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic [EW-1:0] energy_i,
  input  logic [PW-1:0] pmax_i,
  output logic [TW-1:0] per_o,
  output logic          done_o
);
  localparam int CNTW = $clog2(NUMW + 1);

  logic [NUMW-1:0] num_q, quo_q, num_ld, bias;
  logic [PW-1:0]   rem_q, den_q, rem_dif;
  logic [PW:0]     rem_sh;
  logic [CNTW-1:0] cnt_q;
  logic            done_q, ge;

  // ceil(e*K/p) as floor((e*K + p-1)/p); p = 0 gives all ones
  assign bias    = (pmax_i == '0) ? '0 : NUMW'(pmax_i - PW'(1));
  assign num_ld  = NUMW'(energy_i) * NUMW'(K_SCALE) + bias;
  assign rem_sh  = {rem_q, num_q[NUMW-1]};
  assign ge      = rem_sh >= {1'b0, den_q};
  assign rem_dif = rem_sh[PW-1:0] - den_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (kick_i) begin
      num_q  <= num_ld;
      den_q  <= pmax_i;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= CNTW'(NUMW);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      num_q  <= {num_q[NUMW-2:0], 1'b0};
      rem_q  <= ge ? rem_dif : rem_sh[PW-1:0];
      quo_q  <= {quo_q[NUMW-2:0], ge};
      cnt_q  <= cnt_q - CNTW'(1);
      done_q <= (cnt_q == CNTW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  generate
    if (NUMW > TW) begin : g_sat
      assign per_o = (|quo_q[NUMW-1:TW]) ? '1 : quo_q[TW-1:0];
    end else begin : g_ext
      assign per_o = TW'(quo_q);
    end
  endgenerate

  assign done_o = done_q;
endmodule

// File: rtl/vscan_seq.sv
`timescale 1ns/1ps
module vscan_seq #(
  parameter int SW = 8,
  parameter int VW = 8,
  parameter int IW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          adv_i,
  input  logic [SW-1:0] n_sff_i,
  input  logic [VW-1:0] n_comb_i,
  output logic          cap_o,
  output logic          nxt_cap_o,
  output logic          last_o,
  output logic [IW-1:0] idx_o
);
  logic          cap_q;
  logic [SW+1:0] seg_q;  // shift cycles left in segment after the current one
  logic [VW-1:0] vec_q;  // captures still to come
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      seg_q <= '0;
      vec_q <= '0;
      idx_q <= '0;
    end else if (init_i) begin
      cap_q <= 1'b0;
      seg_q <= {1'b0, n_sff_i, 1'b0} + (SW+2)'(3);  // flush + first load
      vec_q <= n_comb_i;
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + IW'(1);
      if (cap_q) begin
        cap_q <= 1'b0;
        seg_q <= {2'b00, n_sff_i} - (SW+2)'(1);
      end else if (seg_q != '0) begin
        seg_q <= seg_q - (SW+2)'(1);
      end else if (vec_q != '0) begin
        cap_q <= 1'b1;
        vec_q <= vec_q - VW'(1);
      end
    end
  end

  assign cap_o     = cap_q;
  assign nxt_cap_o = !cap_q && (seg_q == '0) && (vec_q != '0);
  assign last_o    = !cap_q && (seg_q == '0) && (vec_q == '0);
  assign idx_o     = idx_q;
endmodule

// File: rtl/vscan_clk_gen.sv
`timescale 1ns/1ps
module vscan_clk_gen
  import vscan_pkg::*;
#(
  parameter int EW      = 8,
  parameter int PW      = 8,
  parameter int K_SCALE = 4,
  parameter int TW      = 12,
  parameter int AW      = 4,
  parameter int SW      = 8,
  parameter int VW      = 8,
  parameter int CW      = 32,
  localparam int IW     = SW + VW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sync_mode_i,
  input  logic [PW-1:0] p_max_i,
  input  logic [EW-1:0] e_max_i,
  input  logic [TW-1:0] min_shift_i,
  input  logic [TW-1:0] min_cap_i,
  input  logic [TW-1:0] high_i,
  input  logic [SW-1:0] n_sff_i,
  input  logic [VW-1:0] n_comb_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [EW-1:0] mem_data_i,
  output logic          scan_clk_o,
  output logic          scan_en_o,
  output logic [IW-1:0] cycle_idx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] tick_cnt_o
);
  localparam int KS_W  = $clog2(K_SCALE);
  localparam int NUMW  = (((EW + KS_W) > PW) ? (EW + KS_W) : PW) + 1;
  localparam int FLOOR = NUMW + 2;  // divider must finish inside one period
  localparam logic [TW:0] FLOOR_V = (TW+1)'(FLOOR);

  vscan_st_e     st_q, st_d;
  logic [TW-1:0] ph_q, ph_d, per_q, per_d, hi_eff, div_per, new_per;
  logic          clk_q, clk_d, done_q;
  logic [CW-1:0] tick_q;
  logic          cap, nxt_cap, last, init, adv, fin, div_kick, div_done;
  logic          last_tick, load_cap;
  logic [IW-1:0] idx;
  logic [AW-1:0] raddr, idx_nx;
  logic [EW-1:0] mem_rd, div_e;
  logic [TW:0]   c_div, c_min, c_hi, m1, m2, mx;

  vscan_energy_mem #(.EW(EW), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rd)
  );

  vscan_period_div #(
    .EW(EW), .PW(PW), .K_SCALE(K_SCALE), .NUMW(NUMW), .TW(TW)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (div_kick),
    .energy_i (div_e),
    .pmax_i   (p_max_i),
    .per_o    (div_per),
    .done_o   (div_done)
  );

  vscan_seq #(.SW(SW), .VW(VW), .IW(IW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .adv_i     (adv),
    .n_sff_i   (n_sff_i),
    .n_comb_i  (n_comb_i),
    .cap_o     (cap),
    .nxt_cap_o (nxt_cap),
    .last_o    (last),
    .idx_o     (idx)
  );

  // look-ahead fetch: the next cycle's energy is divided during the current one
  assign idx_nx = idx[AW-1:0] + AW'(1);
  assign raddr  = (st_q == ST_IDLE) ? '0 : idx_nx;
  assign div_e  = sync_mode_i ? e_max_i : mem_rd;

  assign hi_eff    = (high_i < TW'(2)) ? TW'(2) : high_i;
  assign last_tick = (st_q == ST_RUN) && (ph_q == per_q - TW'(1));
  assign load_cap  = (st_q == ST_RUN) ? nxt_cap : 1'b0;
  assign div_kick  = init || ((st_q == ST_RUN) && (ph_q == '0));

  assign c_div   = {1'b0, div_per};
  assign c_min   = {1'b0, (load_cap ? min_cap_i : min_shift_i)};
  assign c_hi    = {1'b0, hi_eff} + (TW+1)'(1);
  assign m1      = (c_div > c_min) ? c_div : c_min;
  assign m2      = (FLOOR_V > c_hi) ? FLOOR_V : c_hi;
  assign mx      = (m1 > m2) ? m1 : m2;
  assign new_per = mx[TW] ? '1 : mx[TW-1:0];

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    per_d = per_q;
    init  = 1'b0;
    adv   = 1'b0;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_PREP;
          init = 1'b1;
        end
      end
      ST_PREP: begin
        if (div_done) begin
          st_d  = ST_RUN;
          ph_d  = '0;
          per_d = new_per;
        end
      end
      ST_RUN: begin
        if (last_tick) begin
          if (last) begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end else begin
            ph_d  = '0;
            per_d = new_per;
            adv   = 1'b1;
          end
        end else begin
          ph_d = ph_q + TW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign clk_d = (st_d == ST_RUN) && (ph_d < hi_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      per_q  <= '0;
      clk_q  <= 1'b0;
      done_q <= 1'b0;
      tick_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      per_q <= per_d;
      clk_q <= clk_d;
      if (init)     done_q <= 1'b0;
      else if (fin) done_q <= 1'b1;
      if (init)                  tick_q <= '0;
      else if (st_q == ST_RUN)   tick_q <= tick_q + CW'(1);
    end
  end

  assign scan_clk_o  = clk_q;
  assign scan_en_o   = (st_q == ST_RUN) && !cap;
  assign cycle_idx_o = idx;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign tick_cnt_o  = tick_q;
endmodule

// File: rtl/vscan_clk_gen_chk.sv
`timescale 1ns/1ps
module vscan_clk_gen_chk #(
  parameter int IW = 18,
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scan_clk_o,
  input logic          scan_en_o,
  input logic [IW-1:0] cycle_idx_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] tick_cnt_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scan_clk_o && !scan_en_o));

  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(cycle_idx_o)) |->
      ($rose(scan_clk_o) && (cycle_idx_o == $past(cycle_idx_o) + IW'(1))));

  p_en_at_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$rose(scan_clk_o)) |-> $stable(scan_en_o));

  p_high_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_clk_o) |-> $past(scan_clk_o, 2));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_tick_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      ((tick_cnt_o == $past(tick_cnt_o)) || (tick_cnt_o == $past(tick_cnt_o) + CW'(1))));
endmodule

bind vscan_clk_gen vscan_clk_gen_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_clk_o  (scan_clk_o),
  .scan_en_o   (scan_en_o),
  .cycle_idx_o (cycle_idx_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tick_cnt_o  (tick_cnt_o)
);

// File: tb/vscan_clk_gen_tb_top.sv
`timescale 1ns/1ps
module vscan_clk_gen_tb_top;
  localparam int FLOOR = 13;

  typedef struct packed {
    logic        sync;
    logic [7:0]  p;
    logic [7:0]  emax;
    logic [11:0] mins;
    logic [11:0] minc;
    logic [11:0] high;
    logic [7:0]  nsff;
    logic [7:0]  ncomb;
  } cfg_t;

  localparam cfg_t TBL [5] = '{
    '{sync:1'b0, p:8'd8,   emax:8'd0,   mins:12'd13, minc:12'd20,  high:12'd3,  nsff:8'd3, ncomb:8'd2},
    '{sync:1'b1, p:8'd8,   emax:8'd200, mins:12'd13, minc:12'd150, high:12'd5,  nsff:8'd3, ncomb:8'd2},
    '{sync:1'b0, p:8'd255, emax:8'd0,   mins:12'd16, minc:12'd30,  high:12'd0,  nsff:8'd4, ncomb:8'd1},
    '{sync:1'b0, p:8'd16,  emax:8'd0,   mins:12'd13, minc:12'd13,  high:12'd40, nsff:8'd2, ncomb:8'd3},
    '{sync:1'b0, p:8'd4,   emax:8'd0,   mins:12'd0,  minc:12'd0,   high:12'd2,  nsff:8'd1, ncomb:8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sync_mode_i = 1'b0;
  logic [7:0]  p_max_i = 8'd1;
  logic [7:0]  e_max_i = '0;
  logic [11:0] min_shift_i = '0;
  logic [11:0] min_cap_i = '0;
  logic [11:0] high_i = '0;
  logic [7:0]  n_sff_i = 8'd1;
  logic [7:0]  n_comb_i = '0;
  logic        mem_we_i = 1'b0;
  logic [3:0]  mem_addr_i = '0;
  logic [7:0]  mem_data_i = '0;
  logic        scan_clk_o, scan_en_o, busy_o, done_o;
  logic [17:0] cycle_idx_o;
  logic [31:0] tick_cnt_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vscan_clk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sync_mode_i(sync_mode_i),
    .p_max_i(p_max_i), .e_max_i(e_max_i), .min_shift_i(min_shift_i),
    .min_cap_i(min_cap_i), .high_i(high_i), .n_sff_i(n_sff_i), .n_comb_i(n_comb_i),
    .mem_we_i(mem_we_i), .mem_addr_i(mem_addr_i), .mem_data_i(mem_data_i),
    .scan_clk_o(scan_clk_o), .scan_en_o(scan_en_o), .cycle_idx_o(cycle_idx_o),
    .busy_o(busy_o), .done_o(done_o), .tick_cnt_o(tick_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int energy_of(input int i);
    return (((i % 16) * 37) + 11) & 255;
  endfunction

  function automatic int n_cycles(input cfg_t c);
    return (int'(c.ncomb) + 2) * int'(c.nsff) + int'(c.ncomb) + 4;
  endfunction

  function automatic bit is_cap(input cfg_t c, input int i);
    int first, k;
    first = 2 * int'(c.nsff) + 4;
    if (i < first) return 1'b0;
    k = i - first;
    return ((k % (int'(c.nsff) + 1)) == 0) && ((k / (int'(c.nsff) + 1)) < int'(c.ncomb));
  endfunction

  function automatic int hi_of(input cfg_t c);
    return (int'(c.high) < 2) ? 2 : int'(c.high);
  endfunction

  function automatic int exp_per(input cfg_t c, input int i);
    int e, q, r;
    e = c.sync ? int'(c.emax) : energy_of(i);
    q = (4 * e + int'(c.p) - 1) / int'(c.p);
    r = q;
    if ((is_cap(c, i) ? int'(c.minc) : int'(c.mins)) > r)
      r = is_cap(c, i) ? int'(c.minc) : int'(c.mins);
    if (FLOOR > r) r = FLOOR;
    if (hi_of(c) + 1 > r) r = hi_of(c) + 1;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic apply_cfg(input cfg_t c);
    sync_mode_i = c.sync;
    p_max_i     = c.p;
    e_max_i     = c.emax;
    min_shift_i = c.mins;
    min_cap_i   = c.minc;
    high_i      = c.high;
    n_sff_i     = c.nsff;
    n_comb_i    = c.ncomb;
  endtask

  task automatic run_cfg(input cfg_t c, input bit restart, input int row);
    int t, ncyc, rise_t, hcnt, total, nexp;
    bit prev, seen_done;
    nexp = n_cycles(c);
    total = 0;
    for (int i = 0; i < nexp; i++) total += exp_per(c, i);
    @(negedge clk);
    apply_cfg(c);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", $sformatf("row %0d busy after start", row), busy_o, 1);
    chk(done_o == 1'b0, "R8", $sformatf("row %0d done cleared by start", row), done_o, 0);
    t = 0; ncyc = 0; rise_t = 0; hcnt = 0; prev = 1'b0; seen_done = 1'b0;
    for (int g = 0; g < 60000; g++) begin
      if (done_o) begin
        seen_done = 1'b1;
        break;
      end
      if (scan_clk_o && !prev) begin
        if (ncyc > 0) begin
          chk(t - rise_t == exp_per(c, ncyc - 1), c.sync ? "R6" : "R4",
              $sformatf("row %0d period of cycle %0d", row, ncyc - 1), t - rise_t, exp_per(c, ncyc - 1));
          chk(hcnt == hi_of(c), "R7", $sformatf("row %0d high time cycle %0d", row, ncyc - 1), hcnt, hi_of(c));
        end
        chk(scan_en_o == !is_cap(c, ncyc), "R3",
            $sformatf("row %0d scan enable cycle %0d", row, ncyc), scan_en_o, !is_cap(c, ncyc));
        chk(int'(cycle_idx_o) == ncyc, "R2", $sformatf("row %0d cycle index", row), cycle_idx_o, ncyc);
        rise_t = t;
        hcnt = 0;
        ncyc++;
      end
      if (scan_clk_o) hcnt++;
      prev = scan_clk_o;
      @(negedge clk);
      t++;
      if (restart && t == 40) start_i = 1'b1;  // R10: must be ignored
      if (restart && t == 41) start_i = 1'b0;
    end
    chk(seen_done, "R8", $sformatf("row %0d run completed", row), seen_done, 1);
    if (ncyc > 0) begin
      chk(t - rise_t == exp_per(c, ncyc - 1), c.sync ? "R6" : "R4",
          $sformatf("row %0d period of last cycle", row), t - rise_t, exp_per(c, ncyc - 1));
      chk(hcnt == hi_of(c), "R7", $sformatf("row %0d high time last cycle", row), hcnt, hi_of(c));
    end
    chk(ncyc == nexp, restart ? "R10" : "R2", $sformatf("row %0d number of periods", row), ncyc, nexp);
    chk(int'(tick_cnt_o) == total, restart ? "R10" : "R9", $sformatf("row %0d tick total", row),
        tick_cnt_o, total);
    chk(busy_o == 1'b0 && scan_clk_o == 1'b0, "R8", $sformatf("row %0d idle after run", row),
        {busy_o, scan_clk_o}, 0);
  endtask

  initial begin
    #750000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scan_clk_o == 1'b0, "R1", "scan clock in reset", scan_clk_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(scan_en_o == 1'b0, "R1", "scan enable idle", scan_en_o, 0);
    chk(tick_cnt_o == 32'd0, "R1", "tick count after reset", tick_cnt_o, 0);

    for (int i = 0; i < 16; i++) begin
      mem_we_i   = 1'b1;
      mem_addr_i = 4'(i);
      mem_data_i = 8'(energy_of(i));
      @(negedge clk);
    end
    mem_we_i = 1'b0;

    for (int r = 0; r < 5; r++) run_cfg(TBL[r], r == 1, r);

    // done holds until next start
    repeat (5) @(negedge clk);
    chk(done_o == 1'b1, "R8", "done held while idle", done_o, 1);
    chk(scan_clk_o == 1'b0 && scan_en_o == 1'b0, "R1", "outputs quiet while idle",
        {scan_clk_o, scan_en_o}, 0);

    // reset in the middle of a run
    apply_cfg(TBL[0]);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done after mid-run reset", {busy_o, done_o}, 0);
    chk(scan_clk_o == 1'b0 && scan_en_o == 1'b0, "R1", "clock/enable after mid-run reset",
        {scan_clk_o, scan_en_o}, 0);
    chk(tick_cnt_o == 32'd0, "R1", "tick count after mid-run reset", tick_cnt_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 again after reset: table kept, capture minimum dominates
    run_cfg(TBL[2], 1'b0, 5);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule